// File: doc/BRIEF.md
# Interrupt-Aware CPU Speed Setting Controller

This block holds the CPU's active power/speed setting: a clock divisor code, a clock source select, a main-oscillator disable bit and a PLL disable bit. Software cannot write the active setting over the bus. It changes only in three ways: a speed instruction that carries an 8-bit immediate, entry into an interrupt service routine, or return from one.

A second setting, used while a service routine runs, can be read and written over the bus. On interrupt entry the active setting is copied into a single save register, and the interrupt setting is loaded in its place. The return pulse carries a restore flag. When the flag is set, the saved setting comes back. When it is clear, the current setting stays.

Two speed instructions on consecutive cycles are illegal. The second one is ignored and reported on a one-cycle flag. A speed instruction that arrives while flash is busy is also ignored, and it sets a sticky error bit that any bus write clears. The block produces no clocks. Downstream clock logic decodes the fields it outputs.

Top module: `spdmode_ctl`

## Requirements
- R1: After reset the active setting is all zero: divisor code 0, source 0 (main oscillator), both disable bits clear. The interrupt setting, the illegal flag and the busy error are also zero.
- R2: A bus write loads the interrupt setting, which reads back on `isr_rdata` from the next cycle. Byte layout is bit [3:0] divisor, [5:4] source, [6] oscillator disable, [7] PLL disable.
- R3: On `irq_enter` the active setting takes the interrupt setting held before that edge, and the previous active setting is saved. Entry has priority over return and over a speed instruction in the same cycle; a speed instruction in that cycle is dropped without any flag.
- R4: On `irq_return` with `ret_restore`=1 the active setting takes the saved value. With `ret_restore`=0 it is unchanged. Return has priority over a speed instruction in the same cycle.
- R5: A speed strobe in the cycle right after another speed strobe is ignored, and `illegal_seq` is high for exactly the following cycle. This holds whether or not the first strobe was accepted.
- R6: A non-illegal speed strobe with no interrupt event and `flash_busy`=0 loads the immediate into the active setting, using the R2 byte layout, on the next edge. If `flash_busy`=1, the active setting does not change.
- R7: A speed strobe rejected for flash busy sets `busy_err`, which stays set until a bus write. If a set and a clear fall in the same cycle, the set wins.
- R8: Without a speed strobe, `irq_enter` or `irq_return`, the active setting holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd_strobe | input | 1 | Speed instruction executes |
| spd_imm | input | 8 | Speed instruction immediate |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_return | input | 1 | Return-from-interrupt pulse |
| ret_restore | input | 1 | Restore the saved setting on return |
| isr_wr | input | 1 | Bus write to the interrupt setting |
| isr_wdata | input | 8 | Bus write data |
| flash_busy | input | 1 | Flash operation in progress |
| cur_div | output | 4 | Active divisor code |
| cur_src | output | 2 | Active clock source |
| cur_osc_off | output | 1 | Active main-oscillator disable |
| cur_pll_off | output | 1 | Active PLL disable |
| isr_rdata | output | 8 | Interrupt setting readback |
| illegal_seq | output | 1 | Back-to-back speed instruction seen |
| busy_err | output | 1 | Sticky flash-busy rejection |

## Verification
Every piece of state except the save register appears at the ports one edge after it changes, so a wrong active or interrupt setting shows up on the cur_* fields or on `isr_rdata` within a cycle. A corrupted save register stays hidden until the next return with restore, so the stimulus places such returns after entries across varied gaps. A wrong back-to-back tracker shows as a missing or extra `illegal_seq` pulse one cycle later, and also as an accepted second instruction on the active fields.

// File: rtl/spdmode_ctl.sv
module spdmode_ctl #(
  parameter int DIV_W = 4,
  parameter int SRC_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spd_strobe,
  input  logic [DIV_W+SRC_W+1:0] spd_imm,
  input  logic                   irq_enter,
  input  logic                   irq_return,
  input  logic                   ret_restore,
  input  logic                   isr_wr,
  input  logic [DIV_W+SRC_W+1:0] isr_wdata,
  input  logic                   flash_busy,
  output logic [DIV_W-1:0]       cur_div,
  output logic [SRC_W-1:0]       cur_src,
  output logic                   cur_osc_off,
  output logic                   cur_pll_off,
  output logic [DIV_W+SRC_W+1:0] isr_rdata,
  output logic                   illegal_seq,
  output logic                   busy_err
);
  localparam int SW = DIV_W + SRC_W + 2;

  logic [SW-1:0] act_q, isr_q, save_q;
  logic          prev_q, ill_q, berr_q;

  wire no_irq      = ~irq_enter & ~irq_return;
  wire fresh       = spd_strobe & ~prev_q;
  wire spd_take    = fresh & no_irq & ~flash_busy;
  wire spd_blocked = fresh & no_irq & flash_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      save_q <= '0;
    end else if (irq_enter) begin
      save_q <= act_q;
      act_q  <= isr_q;
    end else if (irq_return) begin
      if (ret_restore) act_q <= save_q;
    end else if (spd_take) begin
      act_q <= spd_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      prev_q <= 1'b0;
      ill_q  <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      prev_q <= spd_strobe;
      ill_q  <= spd_strobe & prev_q;
      if (isr_wr) isr_q <= isr_wdata;
      if (spd_blocked)  berr_q <= 1'b1;
      else if (isr_wr)  berr_q <= 1'b0;
    end
  end

  assign cur_div     = act_q[DIV_W-1:0];
  assign cur_src     = act_q[DIV_W+SRC_W-1:DIV_W];
  assign cur_osc_off = act_q[SW-2];
  assign cur_pll_off = act_q[SW-1];
  assign isr_rdata   = isr_q;
  assign illegal_seq = ill_q;
  assign busy_err    = berr_q;
endmodule

// File: rtl/spdmode_ctl_chk.sv
module spdmode_ctl_chk #(
  parameter int DIV_W = 4,
  parameter int SRC_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   spd_strobe,
  input logic [DIV_W+SRC_W+1:0] spd_imm,
  input logic                   irq_enter,
  input logic                   irq_return,
  input logic                   ret_restore,
  input logic                   isr_wr,
  input logic [DIV_W+SRC_W+1:0] isr_wdata,
  input logic                   flash_busy,
  input logic [DIV_W-1:0]       cur_div,
  input logic [SRC_W-1:0]       cur_src,
  input logic                   cur_osc_off,
  input logic                   cur_pll_off,
  input logic [DIV_W+SRC_W+1:0] isr_rdata,
  input logic                   illegal_seq,
  input logic                   busy_err
);
  logic [DIV_W+SRC_W+1:0] act;
  logic                   seen_strobe;
  assign act = {cur_pll_off, cur_osc_off, cur_src, cur_div};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_strobe <= 1'b0;
    else        seen_strobe <= spd_strobe;

  p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    isr_wr |=> isr_rdata == $past(isr_wdata));
  p_entry_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> act == $past(isr_rdata));
  p_ret_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !ret_restore && !irq_enter) |=> $stable(act));
  p_b2b_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_strobe && seen_strobe) |=> illegal_seq);
  p_b2b_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_strobe && seen_strobe && !irq_enter && !irq_return) |=> $stable(act));
  p_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(spd_strobe && seen_strobe) |=> !illegal_seq);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_strobe && flash_busy && !irq_enter && !irq_return) |=> $stable(act));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_err && !isr_wr) |=> busy_err);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!spd_strobe && !irq_enter && !irq_return) |=> $stable(act));
endmodule

bind spdmode_ctl spdmode_ctl_chk #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/spdmode_ctl_bench.sv
`timescale 1ns/1ps
module spdmode_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spd_strobe = 0, irq_enter = 0, irq_return = 0, ret_restore = 0;
  logic isr_wr = 0, flash_busy = 0;
  logic [7:0] spd_imm = 0, isr_wdata = 0;
  logic [3:0] cur_div;
  logic [1:0] cur_src;
  logic cur_osc_off, cur_pll_off, illegal_seq, busy_err;
  logic [7:0] isr_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  spdmode_ctl u_spdmode_ctl (.*);

  always #2 clk = ~clk;

  // behavioural reference
  int m_act = 0, m_isr = 0, m_save = 0, m_ill = 0, m_berr = 0, m_prev = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_isr = 0; m_save = 0; m_ill = 0; m_berr = 0; m_prev = 0;
    end else begin
      int fresh;
      fresh  = (spd_strobe && m_prev == 0) ? 1 : 0;
      m_ill  = (spd_strobe && m_prev == 1) ? 1 : 0;
      m_prev = spd_strobe ? 1 : 0;
      if (isr_wr) m_berr = 0;
      if (irq_enter) begin
        m_save = m_act; m_act = m_isr;
      end else if (irq_return) begin
        if (ret_restore) m_act = m_save;
      end else if (fresh == 1) begin
        if (flash_busy) m_berr = 1;
        else m_act = spd_imm;
      end
      if (isr_wr) m_isr = isr_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 active setting", {cur_pll_off, cur_osc_off, cur_src, cur_div}, m_act);
    chk("R2 isr readback", isr_rdata, m_isr);
    chk("R5 illegal_seq", illegal_seq, m_ill);
    chk("R7 busy_err", busy_err, m_berr);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    {spd_strobe, irq_enter, irq_return, ret_restore, isr_wr, flash_busy} = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 div", cur_div, 0); chk("R1 src", cur_src, 0);
    chk("R1 osc", cur_osc_off, 0); chk("R1 pll", cur_pll_off, 0);
    chk("R1 isr", isr_rdata, 0); chk("R1 flags", {illegal_seq, busy_err}, 0);
    rst_n = 1;
    step();
    // R6 accepted speed instruction, byte layout
    spd_strobe = 1; spd_imm = 8'hA7; step();
    chk("R6 div", cur_div, 4'h7); chk("R6 src", cur_src, 2'd2);
    chk("R6 osc", cur_osc_off, 0); chk("R6 pll", cur_pll_off, 1);
    step();
    // R5 back to back
    spd_strobe = 1; spd_imm = 8'h13; step();
    spd_strobe = 1; spd_imm = 8'h55; step();
    chk("R5 second ignored", cur_div, 4'h3);
    chk("R5 flag", illegal_seq, 1);
    step();
    chk("R5 flag one cycle", illegal_seq, 0);
    // R6/R7 flash busy
    spd_strobe = 1; flash_busy = 1; spd_imm = 8'h4F; step();
    chk("R6 busy ignored", cur_div, 4'h3);
    chk("R7 sticky set", busy_err, 1);
    step(); step();
    chk("R7 sticky holds", busy_err, 1);
    // R2 write, clears busy_err
    isr_wr = 1; isr_wdata = 8'h6C; step();
    chk("R2 readback", isr_rdata, 8'h6C);
    chk("R7 cleared", busy_err, 0);
    // R3 entry with competing speed instruction
    irq_enter = 1; spd_strobe = 1; spd_imm = 8'h01; step();
    chk("R3 entry loads", {cur_pll_off, cur_osc_off, cur_src, cur_div}, 8'h6C);
    step();
    // R4 return without restore
    irq_return = 1; ret_restore = 0; step();
    chk("R4 keep", {cur_pll_off, cur_osc_off, cur_src, cur_div}, 8'h6C);
    irq_enter = 1; step();
    irq_return = 1; ret_restore = 1; step();
    chk("R4 restore", {cur_pll_off, cur_osc_off, cur_src, cur_div}, 8'h6C);
    // R7 set wins over clear
    spd_strobe = 1; flash_busy = 1; isr_wr = 1; isr_wdata = 8'h21; step();
    chk("R7 set wins", busy_err, 1);
    // R8 idle hold
    repeat (4) step();
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      spd_strobe  = ($urandom_range(0, 3) == 0);
      spd_imm     = 8'($urandom);
      irq_enter   = ($urandom_range(0, 9) == 0);
      irq_return  = ($urandom_range(0, 7) == 0);
      ret_restore = $urandom_range(0, 1) == 1;
      isr_wr      = ($urandom_range(0, 9) == 0);
      isr_wdata   = 8'($urandom);
      flash_busy  = ($urandom_range(0, 3) == 0);
      step();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule